// File: doc/BRIEF.md
# Machine Timer Compare Unit

This unit is a per-core machine timer. A free-running counter of twice the bus word width advances once per clock. It is held as a low word and a high word, and the low word carries into the high word. A match value of the same width is split into two writable words. Whenever the counter meets or passes the match value under the rule below, a registered interrupt level goes to the processor core. Software reaches the unit through a plain word-wide port with an address, a write enable, write data, a read strobe and combinational read data.

The interrupt fires under two conditions. The first is that the counter's high word is strictly above the match high word. The second is that the two high words are equal and the two low words are exactly equal. A low word that overtakes the match while the high words are equal does not raise the interrupt, but a counter that steps by one always passes through the equal value. While both match words are zero the interrupt stays quiet. The counter words can be read but not written.

The address decode uses these offsets. The match words sit at 0x4000 (low) and 0x4004 (high). The counter words sit at 0xBFF8 (low) and 0xBFFC (high). Any other offset reads as zero and ignores writes.

Top module: `mtimer_cmp`

## Requirements
- R1: After reset the counter is zero. It then grows by exactly one on every clock edge, wrapping at the full double-word width. Its low word reads at offset 0xBFF8.
- R2: When the low word steps from all-ones to zero, the high word grows by one on that same edge. The high word reads at offset 0xBFFC.
- R3: A write to 0xBFF8 or 0xBFFC has no effect on the counter.
- R4: The match low word is written and read at offset 0x4000, and the match high word at 0x4004. A write takes effect on the clock edge that samples it. Without a write to its offset, a match word holds its value.
- R5: `irq` is a register. After each edge it is 1 exactly when the new counter value (high H, low L) and the match value held before that edge (high MH, low ML) satisfy H > MH, or H == MH and L == ML. The match value must also be nonzero.
- R6: While both match words are zero, `irq` is 0 on the following edge, whatever the counter holds.
- R7: A read at any offset other than the four mapped ones returns zero, and a write there changes no state.
- R8: While `rd_en` is 0, `rd_data` is zero.
- R9: During reset, `irq` is 0 and both match words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register offset within the unit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WORD_W | Combinational read data |
| irq | output | 1 | Registered timer-interrupt level toward the core |

## Verification
Two functions can land on the same edge. A write to a match word can arrive just as the counter reaches the value being written. Separately, the low word's carry into the high word can coincide with the compare deciding that the high word has become strictly greater. The bench provokes the first case by writing match values a few counts ahead of the live counter, so that the write edge coincides with the compare edge. It provokes the second with a narrow word width, where carries are frequent. It judges both against an arithmetic model in which every edge compares the incremented count with the match value held before that edge's write.

// File: rtl/mtcmp_pkg.sv
package mtcmp_pkg;
    localparam logic [15:0] OFF_MATCH_LO = 16'h4000;
    localparam logic [15:0] OFF_MATCH_HI = 16'h4004;
    localparam logic [15:0] OFF_COUNT_LO = 16'hBFF8;
    localparam logic [15:0] OFF_COUNT_HI = 16'hBFFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH_LO,
        SEL_MATCH_HI,
        SEL_COUNT_LO,
        SEL_COUNT_HI
    } sel_e;
endpackage

// File: rtl/mtcmp_counter.sv
module mtcmp_counter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi,
    output logic [WORD_W-1:0] nxt_lo,
    output logic [WORD_W-1:0] nxt_hi
);
    localparam int CW = 2 * WORD_W;

    logic [WORD_W:0] lo_sum;

    always_comb begin
        lo_sum = {1'b0, cnt_lo} + {{WORD_W{1'b0}}, 1'b1};
        nxt_lo = lo_sum[WORD_W-1:0];
        nxt_hi = cnt_hi + {{(WORD_W-1){1'b0}}, lo_sum[WORD_W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({cnt_hi, cnt_lo} == CW'($past({cnt_hi, cnt_lo}) + 1'b1))); // R1

    AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_lo) |=> (cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + 1'b1)); // R2
endmodule

// File: rtl/mtcmp_regs.sv
module mtcmp_regs
    import mtcmp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    output logic [WORD_W-1:0] mat_lo,
    output logic [WORD_W-1:0] mat_hi,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_MLO = ADDR_W'(OFF_MATCH_LO);
    localparam logic [ADDR_W-1:0] A_MHI = ADDR_W'(OFF_MATCH_HI);
    localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(OFF_COUNT_LO);
    localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(OFF_COUNT_HI);

    sel_e sel;

    always_comb begin
        if (addr == A_MLO)      sel = SEL_MATCH_LO;
        else if (addr == A_MHI) sel = SEL_MATCH_HI;
        else if (addr == A_CLO) sel = SEL_COUNT_LO;
        else if (addr == A_CHI) sel = SEL_COUNT_HI;
        else                    sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_lo <= '0;
            mat_hi <= '0;
        end else if (wr_en) begin
            if (sel == SEL_MATCH_LO) mat_lo <= wr_data;
            if (sel == SEL_MATCH_HI) mat_hi <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_MATCH_LO: rd_data = mat_lo;
                SEL_MATCH_HI: rd_data = mat_hi;
                SEL_COUNT_LO: rd_data = cnt_lo;
                SEL_COUNT_HI: rd_data = cnt_hi;
                default:      rd_data = '0;
            endcase
        end
    end

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_MLO || addr == A_MHI)) |=> $stable(mat_lo) && $stable(mat_hi)); // R4
endmodule

// File: rtl/mtcmp_compare.sv
module mtcmp_compare #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] nxt_lo,
    input  logic [WORD_W-1:0] nxt_hi,
    input  logic [WORD_W-1:0] mat_lo,
    input  logic [WORD_W-1:0] mat_hi,
    output logic              irq_q
);
    logic armed;
    logic hi_above;
    logic exact;
    logic irq_d;

    always_comb begin
        armed    = |{mat_hi, mat_lo};
        hi_above = nxt_hi > mat_hi;
        exact    = (nxt_hi == mat_hi) && (nxt_lo == mat_lo);
        irq_d    = armed && (hi_above || exact);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mat_lo == '0 && mat_hi == '0) |=> !irq_q); // R6

    AST_EXACT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (mat_lo != '0 && nxt_lo == mat_lo && nxt_hi == mat_hi) |=> irq_q); // R5
endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp
    import mtcmp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    logic [WORD_W-1:0] cnt_lo, cnt_hi, nxt_lo, nxt_hi, mat_lo, mat_hi;

    mtcmp_counter #(.WORD_W(WORD_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .nxt_lo (nxt_lo),
        .nxt_hi (nxt_hi)
    );

    mtcmp_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .mat_lo  (mat_lo),
        .mat_hi  (mat_hi),
        .rd_data (rd_data)
    );

    mtcmp_compare #(.WORD_W(WORD_W)) u_compare (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_lo (nxt_lo),
        .nxt_hi (nxt_hi),
        .mat_lo (mat_lo),
        .mat_hi (mat_hi),
        .irq_q  (irq)
    );

    logic mapped;
    always_comb begin
        mapped = (addr == ADDR_W'(OFF_MATCH_LO)) || (addr == ADDR_W'(OFF_MATCH_HI))
              || (addr == ADDR_W'(OFF_COUNT_LO)) || (addr == ADDR_W'(OFF_COUNT_HI));
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (rd_data == '0)); // R7

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0)); // R8
endmodule

// File: tb/mtimer_cmp_tb_top.sv
`timescale 1ns/1ps
module mtimer_cmp_tb_top;
    localparam int AW = 16;
    localparam int WW = 8;
    localparam logic [15:0] A_MLO = 16'h4000, A_MHI = 16'h4004,
                            A_CLO = 16'hBFF8, A_CHI = 16'hBFFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [WW-1:0] rd_data;
    logic          irq;

    always #4 clk = ~clk;

    mtimer_cmp #(.WORD_W(WW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2*WW-1:0] cnt_m = '0;
    logic [WW-1:0]   mlo_m = '0;
    logic [WW-1:0]   mhi_m = '0;

    function automatic logic exp_irq(logic [15:0] c, logic [7:0] lo, logic [7:0] hi);
        if (lo == 0 && hi == 0) return 1'b0;
        return (c[15:8] > hi) || (c[15:8] == hi && c[7:0] == lo);
    endfunction

    function automatic logic [7:0] exp_rd(logic [15:0] a, logic re);
        if (!re) return 8'h00;
        case (a)
            A_MLO:   return mlo_m;
            A_MHI:   return mhi_m;
            A_CLO:   return cnt_m[7:0];
            A_CHI:   return cnt_m[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(logic [15:0] a, logic re);
        if (!re) return "R8";
        case (a)
            A_MLO, A_MHI: return "R4";
            A_CLO:        return "R1";
            A_CHI:        return "R2";
            default:      return "R7";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cnt_m=0x%0h)", tag, act, exp, cnt_m);
        end
    endtask

    task automatic cyc(logic [15:0] a, logic we, logic [7:0] wd, logic re, string tag = "");
        logic ei;
        string it;
        addr = a; wr_en = we; wr_data = wd; rd_en = re;
        @(negedge clk);
        ei = exp_irq(cnt_m + 16'd1, mlo_m, mhi_m);
        it = (mlo_m == 0 && mhi_m == 0) ? "R6" : "R5";
        cnt_m = cnt_m + 16'd1;
        if (we && a == A_MLO) mlo_m = wd;
        if (we && a == A_MHI) mhi_m = wd;
        chk(it, irq, ei);
        chk(tag == "" ? rd_tag(a, re) : tag, rd_data, exp_rd(a, re));
    endtask

    task automatic arm(logic [7:0] lo, logic [7:0] hi);
        cyc(A_MLO, 1'b1, lo, 1'b1, "R4");
        cyc(A_MHI, 1'b1, hi, 1'b1, "R4");
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            case (i % 4)
                0: cyc(A_CLO, 1'b0, 8'h00, 1'b1);
                1: cyc(A_CHI, 1'b0, 8'h00, 1'b1);
                2: cyc(A_MLO, 1'b0, 8'h00, 1'b1);
                default: cyc(A_MHI, 1'b0, 8'h00, 1'b1);
            endcase
        end
    endtask

    initial begin
        logic [15:0] t;
        // R9: reset state
        rd_en = 1'b1; addr = A_MLO;
        repeat (3) @(negedge clk);
        chk("R9", irq, 0);
        chk("R9", rd_data, 0);
        addr = A_MHI; #1 chk("R9", rd_data, 0);
        addr = A_CLO; #1 chk("R9", rd_data, 0);
        rst_n = 1'b1;

        // R1: counting from zero
        run(300);
        // R8: no read strobe
        for (int i = 0; i < 8; i++) cyc(A_CLO, 1'b0, 8'h00, 1'b0, "R8");
        // R3: counter writes ignored
        cyc(A_CLO, 1'b1, 8'hAA, 1'b1, "R3");
        cyc(A_CHI, 1'b1, 8'h55, 1'b1, "R3");
        for (int i = 0; i < 6; i++) cyc(i[0] ? A_CHI : A_CLO, 1'b0, 8'h00, 1'b1, "R3");
        // R7: unmapped writes and reads
        cyc(16'h4008, 1'b1, 8'h3C, 1'b1, "R7");
        cyc(16'h0000, 1'b1, 8'hC3, 1'b1, "R7");
        cyc(16'hBFF4, 1'b0, 8'h00, 1'b1, "R7");
        cyc(A_MLO, 1'b0, 8'h00, 1'b1, "R7");
        cyc(A_MHI, 1'b0, 8'h00, 1'b1, "R7");
        // R2/R6: full wrap with match zero
        for (int i = 0; i < 65600; i++) cyc(i[0] ? A_CHI : A_CLO, 1'b0, 8'h00, 1'b1);

        // R5: exact hit a few counts ahead, then high word passes
        t = cnt_m + 16'd30;  arm(t[7:0], t[15:8]); run(400);
        // R6: disarm
        arm(8'h00, 8'h00); run(40);
        // R5: high only, one above current
        t = cnt_m; arm(8'h00, t[15:8] + 8'd1); run(600);
        // R5: high already greater
        arm(8'h01, 8'h00); run(20);
        arm(8'h00, 8'h00); run(10);
        // write landing on the very edge the count reaches it
        t = cnt_m + 16'd2; arm(t[7:0], t[15:8]); run(20);
        arm(8'h00, 8'h00);
        t = cnt_m + 16'd2; cyc(A_MHI, 1'b1, t[15:8], 1'b1, "R5");
        cyc(A_MLO, 1'b1, t[7:0], 1'b1, "R5"); run(300);
        // low equal but high below: compare waits for high
        arm(8'h00, 8'h00);
        t = cnt_m; arm(t[7:0] + 8'd8, t[15:8] + 8'd1); run(700);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule